// File: doc/BRIEF.md
# 128-bit Vector Bit-Shift Unit

This block shifts a 128-bit source vector left, right with zero fill, or right with sign fill, and returns the result one clock after an operation is issued. It has two ways of applying the shift. In the uniform way the entire vector moves by a single amount read from the count operand. That amount is either a bit amount from 0 to 7, or a byte-granular amount from 0 to 120 in steps of 8.

In the per-byte way, which is available only when the enhancement enable is set, each of the sixteen bytes carries its own 0 to 7 bit amount. Bits shifted out of one byte are refilled from the adjacent source byte, not from zeros. Every byte is derived from the original source bytes, so the result stays correct when the destination register aliases the source.

The operand side is a single-cycle issue pulse (`op_valid`) and has no back-pressure: the unit accepts an operation on every cycle in which `op_valid` is high. The result side is a one-cycle `res_valid` strobe and cannot be stalled. The consumer must take `res_data` in the strobe cycle. `res_data` then holds its value until the next issued operation.

Top module: `vec_shift_unit`

## Requirements
- R1: Per-byte mode is used exactly when `enh_en`=1 and `by_byte`=0. Every other combination uses uniform mode.
- R2: In uniform bit mode (`by_byte`=0), the amount is `count[66:64]`, the low 3 bits of byte 7. All other count bits are ignored.
- R3: In uniform by-byte mode (`by_byte`=1), the amount is `count[71:64]` masked with 8'h78, which gives 0 to 120 in multiples of 8.
- R4: `op_sel` 2'b00 shifts left with zero fill, 2'b01 shifts right with zero fill, and 2'b10 shifts right with copies of bit 127 (uniform mode).
- R5: `op_sel` 2'b11 returns the source unchanged in either mode.
- R6: Byte i occupies bits [127-8i : 120-8i], so byte 0 is the most significant. In per-byte mode, the amount for byte i is the low 3 bits of count byte i.
- R7: For a per-byte left shift, result byte i is bits [15:8] of ({src byte i, src byte i+1} << amount). Byte 15 uses zero as its neighbour.
- R8: For a per-byte right shift with zero fill, result byte i is bits [7:0] of ({src byte i-1, src byte i} >> amount). Byte 0 uses zero as its neighbour.
- R9: For a per-byte right shift with sign fill, bytes 1 to 15 follow R8. Byte 0 fills with its own bit 7.
- R10: An amount of zero returns the source unchanged, in either mode.
- R11: `res_valid` is high for exactly the one cycle after a cycle with `op_valid`=1, and `res_data` then carries that operation's result. Without `op_valid`, `res_data` holds its value.
- R12: A synchronous active-high `rst` clears `res_data` to zero and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue pulse: the operands are taken this cycle |
| src | input | 128 | Source vector, byte 0 at bits 127:120 |
| count | input | 128 | Count operand |
| op_sel | input | 2 | 00 left, 01 right zero-fill, 10 right sign-fill, 11 pass |
| by_byte | input | 1 | Uniform amount in whole bytes |
| enh_en | input | 1 | Enables per-byte mode |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 128 | Registered result |

## Verification
The bound checker watches several properties on every cycle: the strobe timing, the holding of the result while idle, pass-through for `op_sel` 2'b11, identity for a zero uniform amount, and the reset state. The bench's scenarios cover the data values for the other cases. These include the neighbour-byte carry in each direction, the zero neighbour at bytes 0 and 15, sign fill confined to byte 0, the 8'h78 mask, and the fact that non-selected count bits are ignored. A bench model computes each of these bit by bit, and literal vectors confirm the edge bytes.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RLOG  = 2'b01,
    SH_RARI  = 2'b10,
    SH_PASS  = 2'b11
  } shift_op_e;
endpackage

// File: rtl/vshift_uniform.sv
module vshift_uniform
  import vshift_pkg::*;
#(
  parameter int W = 128,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  shift_op_e     op_i,
  output logic [W-1:0]  data_o
);
  always_comb begin
    unique case (op_i)
      SH_LEFT: data_o = data_i << amt_i;
      SH_RLOG: data_o = data_i >> amt_i;
      SH_RARI: data_o = W'($signed(data_i) >>> amt_i);
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/vshift_perbyte.sv
module vshift_perbyte
  import vshift_pkg::*;
#(
  parameter int W = 128,
  parameter int BW = 8,
  localparam int NB = W / BW,
  localparam int SW = $clog2(BW)
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] cnt_i,
  input  shift_op_e    op_i,
  output logic [W-1:0] data_o
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam int HI = W - 1 - BW * i;
    logic [BW-1:0]   own_b, lo_nb, hi_nb;
    logic [SW-1:0]   sh;
    logic [2*BW-1:0] lwin, rwin;

    assign own_b = data_i[HI -: BW];
    assign sh    = cnt_i[HI-BW+SW : HI-BW+1];

    if (i == NB - 1) begin : g_last
      assign lo_nb = '0;
    end else begin : g_mid_l
      assign lo_nb = data_i[HI-BW -: BW];
    end

    if (i == 0) begin : g_first
      assign hi_nb = (op_i == SH_RARI) ? {BW{own_b[BW-1]}} : '0;
    end else begin : g_mid_r
      assign hi_nb = data_i[HI+BW -: BW];
    end

    assign lwin = {own_b, lo_nb} << sh;
    assign rwin = {hi_nb, own_b} >> sh;

    always_comb begin
      unique case (op_i)
        SH_LEFT:          data_o[HI -: BW] = lwin[2*BW-1 -: BW];
        SH_RLOG, SH_RARI: data_o[HI -: BW] = rwin[BW-1:0];
        default:          data_o[HI -: BW] = own_b;
      endcase
    end
  end
endmodule

// File: rtl/vec_shift_unit.sv
module vec_shift_unit
  import vshift_pkg::*;
#(
  parameter int W = 128,
  parameter int BW = 8,
  parameter int AMT_BYTE = 7,
  localparam int AW = $clog2(W),
  localparam int SW = $clog2(BW),
  localparam int ALO = W - BW * (AMT_BYTE + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [W-1:0] src,
  input  logic [W-1:0] count,
  input  logic [1:0]   op_sel,
  input  logic         by_byte,
  input  logic         enh_en,
  output logic         res_valid,
  output logic [W-1:0] res_data
);
  shift_op_e      op;
  logic [BW-1:0]  amt_byte;
  logic [AW-1:0]  uni_amt;
  logic [W-1:0]   uni_res, pb_res, next_res;
  logic           per_byte_mode;

  assign op            = shift_op_e'(op_sel);
  assign amt_byte      = count[ALO +: BW];
  assign per_byte_mode = enh_en && !by_byte;

  always_comb begin
    uni_amt = '0;
    if (by_byte) uni_amt[AW-1:SW] = amt_byte[AW-1:SW];
    else         uni_amt[SW-1:0]  = amt_byte[SW-1:0];
  end

  vshift_uniform #(.W(W)) u_uni (
    .data_i(src), .amt_i(uni_amt), .op_i(op), .data_o(uni_res)
  );

  vshift_perbyte #(.W(W), .BW(BW)) u_pb (
    .data_i(src), .cnt_i(count), .op_i(op), .data_o(pb_res)
  );

  assign next_res = per_byte_mode ? pb_res : uni_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= next_res;
    end
  end
endmodule

// File: rtl/vec_shift_checker.sv
module vec_shift_checker #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [W-1:0] src,
  input logic [W-1:0] count,
  input logic [1:0]   op_sel,
  input logic         by_byte,
  input logic         enh_en,
  input logic         res_valid,
  input logic [W-1:0] res_data
);
  logic uni_zero;
  assign uni_zero = !(enh_en && !by_byte) &&
                    (by_byte ? (count[70:67] == 4'd0) : (count[66:64] == 3'd0));

  p_strobe_after_issue_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_data));
  p_pass_op_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'b11) |=> res_data == $past(src));
  p_zero_amount_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && uni_zero) |=> res_data == $past(src));
  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));
endmodule

bind vec_shift_unit vec_shift_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .src(src), .count(count),
  .op_sel(op_sel), .by_byte(by_byte), .enh_en(enh_en),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/test_vec_shift_unit.sv
module test_vec_shift_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [127:0] src, count;
  logic [1:0]   op_sel;
  logic         by_byte, enh_en;
  logic         res_valid;
  logic [127:0] res_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vec_shift_unit i_vec_shift_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .src(src), .count(count),
    .op_sel(op_sel), .by_byte(by_byte), .enh_en(enh_en),
    .res_valid(res_valid), .res_data(res_data)
  );

  // Stimulus fields: {src, count, op, by_byte, enh_en}
  localparam int NV = 12;
  localparam logic [259:0] VEC [NV] = '{
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'hFFFF_FFFF_FFFF_FF05_FFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b0},
    {128'h8123456789ABCDEF_FEDCBA9876543210, 128'h0000_0000_0000_0007_0000_0000_0000_0000, 2'b01, 1'b0, 1'b0},
    {128'h8123456789ABCDEF_FEDCBA9876543210, 128'h0000_0000_0000_0006_0000_0000_0000_0000, 2'b10, 1'b0, 1'b0},
    {128'hF0E1D2C3B4A59687_7869584A3B2C1D0E, 128'h0000_0000_0000_00FF_0000_0000_0000_0000, 2'b00, 1'b1, 1'b1},
    {128'hF0E1D2C3B4A59687_7869584A3B2C1D0E, 128'h0000_0000_0000_002B_0000_0000_0000_0000, 2'b01, 1'b1, 1'b0},
    {128'hF0E1D2C3B4A59687_7869584A3B2C1D0E, 128'h0000_0000_0000_0019_0000_0000_0000_0000, 2'b10, 1'b1, 1'b0},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0102030405060700_0102030405060700, 2'b00, 1'b0, 1'b1},
    {128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF9FAFBFCFDFEFF08_090A0B0C0D0E0F10, 2'b01, 1'b0, 1'b1},
    {128'h9123456789ABCDEF_FEDCBA9876543210, 128'h0706050403020100_0706050403020100, 2'b10, 1'b0, 1'b1},
    {128'h1123456789ABCDEF_FEDCBA9876543210, 128'h0706050403020100_0706050403020100, 2'b10, 1'b0, 1'b1},
    {128'hDEADBEEF01234567_89ABCDEFCAFEF00D, 128'h0303030303030303_0303030303030303, 2'b11, 1'b0, 1'b1},
    {128'hDEADBEEF01234567_89ABCDEFCAFEF00D, 128'h0000_0000_0000_0005_0000_0000_0000_0000, 2'b11, 1'b1, 1'b0}
  };

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] c,
                                         input logic [1:0] op, input logic bb, input logic en);
    logic [127:0] r;
    int a;
    r = '0;
    if (op == 2'b11) return s;
    if (en && !bb) begin
      for (int i = 0; i < 16; i++) begin
        int me, nb, sh, w;
        me = int'(s[127-8*i -: 8]);
        sh = int'(c[122-8*i -: 3]);
        if (op == 2'b00) begin
          nb = (i == 15) ? 0 : int'(s[119-8*i -: 8]);
          w  = (((me * 256 + nb) << sh) >> 8) & 255;
        end else begin
          if (i == 0) nb = (op == 2'b10 && me >= 128) ? 255 : 0;
          else        nb = int'(s[135-8*i -: 8]);
          w  = ((nb * 256 + me) >> sh) & 255;
        end
        r[127-8*i -: 8] = 8'(w);
      end
    end else begin
      a = bb ? int'(c[71:64] & 8'h78) : int'(c[66:64]);
      for (int j = 0; j < 128; j++) begin
        if (op == 2'b00) r[j] = (j >= a) ? s[j-a] : 1'b0;
        else r[j] = (j + a <= 127) ? s[j+a] : (op == 2'b10 ? s[127] : 1'b0);
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [127:0] s, input logic [127:0] c,
                       input logic [1:0] op, input logic bb, input logic en);
    @(negedge clk);
    src = s; count = c; op_sel = op; by_byte = bb; enh_en = en; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [127:0] exp);
    checks++;
    if (res_valid !== 1'b1 || res_data !== exp) begin
      errors++;
      $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h", tag, res_valid, res_data, exp);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] s, input logic [127:0] c,
                     input logic [1:0] op, input logic bb, input logic en, input logic [127:0] exp);
    issue(s, c, op, bb, en);
    check(tag, exp);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    rst = 1'b1; op_valid = 1'b0; src = '1; count = '0; op_sel = 2'b00; by_byte = 1'b0; enh_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      errors++;
      $display("FAIL R12 reset: valid=%b data=%h expected valid=0 data=0", res_valid, res_data);
    end
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 covered by the vectors above.
    for (int k = 0; k < NV; k++) begin
      logic [259:0] v;
      v = VEC[k];
      run($sformatf("R1/R4/R6 vector %0d", k), v[259:132], v[131:4], v[3:2], v[1], v[0],
          model(v[259:132], v[131:4], v[3:2], v[1], v[0]));
    end

    // R7: byte 0 pulls top bit of byte 1, byte 15 takes zero
    run("R7 left neighbour", {8'h01, 8'h80, 104'h0, 8'hFF}, {8'h01, 112'h0, 8'h04}, 2'b00, 1'b0, 1'b1,
        {8'h03, 8'h80, 104'h0, 8'hF0});
    // R8: byte 1 takes low bit of byte 0; byte 0 zero-filled
    run("R8 right neighbour", {8'hF1, 8'h00, 112'h0}, {8'h02, 8'h01, 112'h0}, 2'b01, 1'b0, 1'b1,
        {8'h3C, 8'h80, 112'h0});
    // R9: only byte 0 sign-fills
    run("R9 sign fill byte0", {8'h80, 8'h80, 112'h0}, {8'h03, 8'h03, 112'h0}, 2'b10, 1'b0, 1'b1,
        {8'hF0, 8'h10, 112'h0});
    // R4 uniform sign fill
    run("R4 uniform arith", {8'h80, 120'h0}, {56'h0, 8'h04, 64'h0}, 2'b10, 1'b0, 1'b0,
        {8'hF8, 120'h0});
    // R3 mask 0xFF -> 120
    run("R3 mask max", '1, {56'h0, 8'hFF, 64'h0}, 2'b01, 1'b1, 1'b0, 128'hFF);
    // R2 other count bits ignored
    run("R2 ignore bits", 128'h1, {56'hFFFF_FFFF_FFFF_FF, 8'hFB, 64'hFFFF_FFFF_FFFF_FFFF}, 2'b00, 1'b0, 1'b0,
        128'h8);
    // R1 by_byte set overrides enh_en: per-byte amounts ignored
    run("R1 by_byte wins", 128'h1, {56'h07070707070707, 8'h08, 64'h0707070707070707}, 2'b00, 1'b1, 1'b1,
        128'h100);
    // R10 all per-byte amounts zero
    run("R10 zero per-byte", 128'hCAFEBABE_DEADBEEF_01234567_89ABCDEF, 128'hF8F8F8F8_F8F8F8F8_F8F8F8F8_F8F8F8F8,
        2'b10, 1'b0, 1'b1, 128'hCAFEBABE_DEADBEEF_01234567_89ABCDEF);

    // R11: strobe drops and data holds without op_valid
    held = res_data;
    src = '0; count = '1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== held) begin
      errors++;
      $display("FAIL R11 hold: valid=%b data=%h expected valid=0 data=%h", res_valid, res_data, held);
    end

    // R12: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      errors++;
      $display("FAIL R12 reset clear: valid=%b data=%h expected valid=0 data=0", res_valid, res_data);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule